// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Vector

This block gathers eight active-low external interrupt pins and eight active-high internal interrupt levels into one sixteen-source pending set. It qualifies that set with a software mask and chooses the winning source by fixed priority. It then drives one interrupt request line towards the processor core and publishes an 8-bit vector code that names the winning source. Each external pin can be set to latch on a falling edge or to follow a low level. The inputs of a pin pass through a two-flop synchronizer before either kind of detection.

Software reaches four registers through a small port. Each register is selected by a 2-bit index and read back combinationally. An interrupt handler reads the pending word to find the cause of an interrupt. For an internal level, it then consults the pending word of the peripheral concentrator that drives that level. The handler acknowledges an edge-latched pin by writing 1 to that pin's bit.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the pending word, mask word, edge-select word, vector and `core_irq` are all zero. Zero in the edge-select word means every pin is in level mode.
- R2: Source index i (0..15) appears at pending-word bit 31-i. Even index 2k is pin k and odd index 2k+1 is internal level k. Bits 15:0 read as zero.
- R3: A level-mode pin held low shows its pending bit three clocks after it changes, counting the two synchronizer flops and the pending flop. The bit clears three clocks after the pin returns high.
- R4: An edge-mode pin sets its pending bit on a falling edge. The bit stays set after the pin goes high. Writing 1 to its bit at index 0 clears it, and writing 0 leaves it set.
- R5: The pending bit of internal level k equals `int_lvl[k]` one clock later.
- R6: Mask bit 31-i (register index 1) at 0 keeps source i out of `core_irq` and out of the vector. Source 0 (pin 0) ignores its mask bit.
- R7: `core_irq` is 1 one clock after the pending word holds any unmasked source, and 0 otherwise.
- R8: The vector is 4 times the lowest unmasked pending index, one clock after the pending word. Pin 0 gives 0x00 and level 7 gives 0x3C. The vector is 0x00 when nothing is pending.
- R9: The register indices are 0 for pending, 1 for mask (bits 31:16), 2 for edge select (pin k at bit 31-k), and 3 for the vector (bits 7:0). Writes to index 3 are ignored. Writes to the pending bits of level-mode pins and of internal levels are ignored.
- R10: Unused bits read as zero in every register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_n | input | 8 | External interrupt pins, active low, asynchronous |
| int_lvl | input | 8 | Internal interrupt levels, active high, synchronous |
| reg_sel | input | 2 | Register index |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_sel` |
| core_irq | output | 1 | Interrupt request to the core |
| vec_code | output | 8 | Vector code of the current winner |

## Verification
The assertions take the internal levels to be synchronous to `clk`. They take register writes to be single-cycle strobes whose data is stable at the edge. The external pins are treated as asynchronous, and only their synchronized view is checked. The stimulus changes the pins and levels only at falling clock edges. It holds each random pattern for at least four clocks, so that the synchronizer and the output registers settle before the bench compares results.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int DEF_NPIN  = 8;
  localparam int DEF_WORD  = 32;
  localparam int DEF_VEC_W = 8;

  // Register indices on the software port
  localparam logic [1:0] SEL_PEND = 2'd0;
  localparam logic [1:0] SEL_MASK = 2'd1;
  localparam logic [1:0] SEL_EDGE = 2'd2;
  localparam logic [1:0] SEL_VEC  = 2'd3;

  // Vector code of priority index idx
  function automatic logic [DEF_VEC_W-1:0] vec_of(input int idx);
    return DEF_VEC_W'(idx * 4);
  endfunction

  // Word bit that carries index idx (index 0 sits at the MSB)
  function automatic int word_bit(input int width, input int idx);
    return width - 1 - idx;
  endfunction
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_n,
  output logic [N-1:0] low_lvl,
  output logic [N-1:0] fall
);
  logic [N-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '1;
      s2_q   <= '1;
      prev_q <= '1;
    end else begin
      s1_q   <= pin_n;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign low_lvl = ~s2_q;
  assign fall    = prev_q & ~s2_q;
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int NPIN = 8,
  localparam int NSRC = 2 * NPIN
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] low_lvl,
  input  logic [NPIN-1:0] fall,
  input  logic [NPIN-1:0] edge_sel,
  input  logic [NPIN-1:0] int_lvl,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] pend
);
  logic [NSRC-1:0] pend_q;

  for (genvar k = 0; k < NPIN; k++) begin : g_src
    // External pin k lives at even index 2k
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           pend_q[2*k] <= 1'b0;
      else if (edge_sel[k]) pend_q[2*k] <= fall[k] | (pend_q[2*k] & ~clr[2*k]);
      else                  pend_q[2*k] <= low_lvl[k];
    end
    // Internal level k lives at odd index 2k+1
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[2*k+1] <= 1'b0;
      else        pend_q[2*k+1] <= int_lvl[k];
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NSRC  = 16,
  parameter int VEC_W = 8
) (
  input  logic [NSRC-1:0]  eff,
  output logic             any,
  output logic [VEC_W-1:0] vec
);
  import irq_ctrl_pkg::*;

  always_comb begin
    any = |eff;
    vec = '0;
    // Scan from the lowest priority up, so index 0 wins
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (eff[i]) vec = VEC_W'(vec_of(i));
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NPIN   = irq_ctrl_pkg::DEF_NPIN,
  parameter int WORD_W = irq_ctrl_pkg::DEF_WORD,
  parameter int VEC_W  = irq_ctrl_pkg::DEF_VEC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPIN-1:0]   irq_pin_n,
  input  logic [NPIN-1:0]   int_lvl,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              core_irq,
  output logic [VEC_W-1:0]  vec_code
);
  import irq_ctrl_pkg::*;
  localparam int NSRC = 2 * NPIN;

  logic [NPIN-1:0]  low_lvl, fall, edge_q;
  logic [NSRC-1:0]  pend_q, mask_q, clr, eff;
  logic             win_any;
  logic [VEC_W-1:0] win_vec;
  logic             wr_pend, wr_mask, wr_edge;

  assign wr_pend = reg_wr && (reg_sel == SEL_PEND);
  assign wr_mask = reg_wr && (reg_sel == SEL_MASK);
  assign wr_edge = reg_wr && (reg_sel == SEL_EDGE);

  irq_pin_sync #(.N(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_n(irq_pin_n),
    .low_lvl(low_lvl), .fall(fall)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_clr
    assign clr[i] = wr_pend & reg_wdata[word_bit(WORD_W, i)];
  end

  irq_pend_reg #(.NPIN(NPIN)) u_pend (
    .clk(clk), .rst_n(rst_n), .low_lvl(low_lvl), .fall(fall),
    .edge_sel(edge_q), .int_lvl(int_lvl), .clr(clr), .pend(pend_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      edge_q <= '0;
    end else begin
      if (wr_mask)
        for (int i = 0; i < NSRC; i++) mask_q[i] <= reg_wdata[word_bit(WORD_W, i)];
      if (wr_edge)
        for (int k = 0; k < NPIN; k++) edge_q[k] <= reg_wdata[word_bit(WORD_W, k)];
    end
  end

  // Source 0 is non-maskable
  assign eff = pend_q & (mask_q | NSRC'(1));

  irq_arbiter #(.NSRC(NSRC), .VEC_W(VEC_W)) u_arb (
    .eff(eff), .any(win_any), .vec(win_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_irq <= 1'b0;
      vec_code <= '0;
    end else begin
      core_irq <= win_any;
      vec_code <= win_vec;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_sel)
      SEL_PEND: for (int i = 0; i < NSRC; i++) reg_rdata[word_bit(WORD_W, i)] = pend_q[i];
      SEL_MASK: for (int i = 0; i < NSRC; i++) reg_rdata[word_bit(WORD_W, i)] = mask_q[i];
      SEL_EDGE: for (int k = 0; k < NPIN; k++) reg_rdata[word_bit(WORD_W, k)] = edge_q[k];
      default:  reg_rdata[VEC_W-1:0] = vec_code;
    endcase
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int NSRC   = 16,
  parameter int WORD_W = 32,
  parameter int VEC_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   pend,
  input logic              core_irq,
  input logic [VEC_W-1:0]  vec,
  input logic [1:0]        reg_sel,
  input logic [WORD_W-1:0] reg_rdata
);
  logic [NSRC-1:0] pend_d, win_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_d <= '0;
    else        pend_d <= pend;
  end

  assign win_sh = pend_d >> (vec >> 2);

  // R6
  nmi_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_d[0] |-> (core_irq && vec == '0));

  // R7
  irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_irq |-> (|pend_d));

  // R8
  vec_names_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_irq |-> (win_sh[0] && vec[1:0] == 2'b00));

  // R8
  idle_vec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !core_irq |-> (vec == '0));

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'd0) |-> (reg_rdata[WORD_W-NSRC-1:0] == '0));
endmodule

bind prio_irq_ctrl irq_ctrl_chk #(.NSRC(NSRC), .WORD_W(WORD_W), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pend(pend_q), .core_irq(core_irq),
  .vec(vec_code), .reg_sel(reg_sel), .reg_rdata(reg_rdata)
);

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq_pin_n = 8'hFF;
  logic [7:0]  int_lvl = 8'h00;
  logic [1:0]  reg_sel = 2'd0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        core_irq;
  logic [7:0]  vec_code;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .int_lvl(int_lvl),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .core_irq(core_irq), .vec_code(vec_code)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
    tick(1);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    reg_sel = sel; #0.5; d = reg_rdata;
  endtask

  // Pending word in register layout, level mode only
  function automatic logic [31:0] exp_pend(input logic [7:0] pins_n, input logic [7:0] lvl);
    logic [31:0] w = '0;
    for (int k = 0; k < 8; k++) begin
      w[31-2*k]   = ~pins_n[k];
      w[31-2*k-1] = lvl[k];
    end
    return w;
  endfunction

  function automatic logic [8:0] exp_win(input logic [31:0] pw, input logic [31:0] mw);
    logic [31:0] e = pw & (mw | 32'h8000_0000);
    for (int i = 0; i < 16; i++)
      if (e[31-i]) return {1'b1, 8'(i << 2)};
    return 9'h000;
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [8:0]  w;
    process::self().srandom(32'd4821);
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    rd(2'd0, r); check("R1", "pending", r, 0);
    rd(2'd1, r); check("R1", "mask", r, 0);
    rd(2'd2, r); check("R1", "edge", r, 0);
    check("R1", "irq", 32'(core_irq), 0);
    check("R1", "vec", 32'(vec_code), 0);

    // R5 level timing, R6 masked source does not request
    int_lvl = 8'h80;
    tick(1); rd(2'd0, r); check("R5", "L7 pend after 1", r, 32'h0001_0000);
    tick(2); check("R6", "masked irq", 32'(core_irq), 0);
    // R8 L7 alone gives 0x3C
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, r); check("R10", "mask read", r, 32'hFFFF_0000);
    tick(1); check("R8", "L7 vec", 32'(vec_code), 32'h3C);
    check("R7", "irq on", 32'(core_irq), 1);
    rd(2'd3, r); check("R9", "vec read", r, 32'h3C);
    wr(2'd3, 32'h0000_0011);
    rd(2'd3, r); check("R9", "vec write ignored", r, 32'h3C);
    int_lvl = 8'h00;

    // R3 level-mode pin 3 (index 6, word bit 25)
    irq_pin_n = 8'hF7;
    tick(2); rd(2'd0, r); check("R3", "pin not yet", r, 0);
    tick(1); rd(2'd0, r); check("R3", "pin pend", r, 32'h0200_0000);
    wr(2'd0, 32'hFFFF_0000);
    rd(2'd0, r); check("R9", "level W1C ignored", r, 32'h0200_0000);
    irq_pin_n = 8'hFF;
    tick(3); rd(2'd0, r); check("R3", "pin released", r, 0);

    // R6 pin 0 ignores mask
    wr(2'd1, 32'h0);
    irq_pin_n = 8'hFE; int_lvl = 8'h01;
    tick(4);
    check("R6", "nmi irq", 32'(core_irq), 1);
    check("R6", "nmi vec", 32'(vec_code), 0);
    rd(2'd0, r); check("R2", "pin0+L0 layout", r, 32'hC000_0000);
    irq_pin_n = 8'hFF; int_lvl = 8'h00;
    tick(4);
    check("R8", "idle vec", 32'(vec_code), 0);

    // R4 edge mode on pin 5 (index 10, word bit 21)
    wr(2'd2, 32'h0400_0000);
    rd(2'd2, r); check("R10", "edge read", r, 32'h0400_0000);
    irq_pin_n = 8'hDF; tick(2); irq_pin_n = 8'hFF;
    tick(6); rd(2'd0, r); check("R4", "edge latched", r, 32'h0020_0000);
    wr(2'd0, 32'hFFDF_0000);
    rd(2'd0, r); check("R4", "write 0 keeps", r, 32'h0020_0000);
    wr(2'd0, 32'h0020_0000);
    rd(2'd0, r); check("R4", "write 1 clears", r, 0);
    wr(2'd2, 32'h0);

    // Random level-mode patterns
    for (int t = 0; t < 300; t++) begin
      logic [31:0] m, pe;
      logic [7:0] pn, lv;
      m = $urandom & 32'hFFFF_0000;
      wr(2'd1, m);
      pn = 8'($urandom | $urandom);
      lv = 8'($urandom & $urandom);
      irq_pin_n = pn; int_lvl = lv;
      tick(4);
      pe = exp_pend(pn, lv);
      w = exp_win(pe, m);
      rd(2'd0, r); check("R2", "rand pend", r, pe);
      check("R7", "rand irq", 32'(core_irq), 32'(w[8]));
      check("R8", "rand vec", 32'(vec_code), 32'(w[7:0]));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule